// File: doc/BRIEF.md
# Floating-Point Rounding Decision Unit

This unit takes an unpacked floating-point mantissa together with the sign and rounding-mode context, and delivers the rounded mantissa one clock cycle later. The two least significant bits of the incoming mantissa are the guard and round positions, and a separate sticky flag stands for every bit that was shifted out beyond them. The unit drops the guard and round bits and decides from the mode and the sign whether to add one at the new least significant position. The increment carries through the whole mantissa. Two flags come with the result: one reports that the increment happened and one reports that the result is inexact.

A second output tells the packing stage which value an overflowing result takes for the current mode and sign: infinity, or the largest finite magnitude. The unit does not renormalise a carry out of the increment, for example a mantissa that becomes 2.0. The consumer detects that case through the rounded-up flag and the top bits, and handles it together with the exponent.

Top module: `fp_round_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `out_valid` is 0. All registered outputs are cleared to zero while reset is high.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock cycle. All result outputs belong to the sample that was presented together with that `in_valid`.
- R3: `mant_out` is `mant_in[MANT_W-1:2]` (the input shifted right by two, with guard = bit 1 and round = bit 0), plus one if and only if `rnd_up` is 1. The sum is taken modulo 2^(MANT_W-2), so an all-ones value wraps to zero.
- R4: When guard, round and sticky are all 0, `inexact` is 0, `rnd_up` is 0 and `mant_out` equals the truncated input, in every mode.
- R5: `inexact` is 1 whenever any of guard, round or sticky is 1, in every mode.
- R6: With mode code 0 (nearest, ties to even), `rnd_up` is 1 exactly when guard is 1 and at least one of these is 1: round, sticky, or the least significant bit of the truncated mantissa.
- R7: With mode code 1 (toward zero), `rnd_up` is always 0.
- R8: With mode code 2 (toward +infinity), `rnd_up` is 1 exactly when the result is inexact and `sign_in` is 0. With mode code 3 (toward -infinity), `rnd_up` is 1 exactly when the result is inexact and `sign_in` is 1.
- R9: `ovf_to_inf` is 1 for mode 0, 0 for mode 1, equal to the inverse of `sign_in` for mode 2, and equal to `sign_in` for mode 3.
- R10: A carry out of the top bit is not renormalised. When the increment overflows the truncated width, `mant_out` is zero and `rnd_up` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is valid |
| mant_in | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_in | input | 1 | OR of all bits below round |
| sign_in | input | 1 | Sign of the value (1 = negative) |
| mode_in | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Result outputs are valid |
| mant_out | output | MANT_W-2 | Rounded mantissa, guard and round removed |
| rnd_up | output | 1 | An increment was applied |
| inexact | output | 1 | Discarded bits were nonzero |
| ovf_to_inf | output | 1 | An overflow should go to infinity (1) or to the largest finite value (0) |

## Verification
All results register together, so each one is due on the clock edge that follows the edge that sampled its input. The bench drives a sample just after a falling edge, lets one rising edge capture it, and samples the outputs at the next falling edge. It compares them there against a reference model computed from the requirements. Samples sent back to back are also checked at the following negative edge, which shows that each output belongs to the sample from exactly one cycle earlier. The expected output of the previous sample is held while the next one is driven.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_POS_INF = 2'd2,
        RM_NEG_INF = 2'd3
    } rmode_e;

    typedef struct packed {
        logic guard;
        logic rnd;
        logic sticky;
        logic lsb;
        logic sign;
    } rbits_t;

    function automatic logic calc_increment(input rmode_e m, input rbits_t b);
        logic any;
        any = b.guard | b.rnd | b.sticky;
        case (m)
            RM_ZERO:    calc_increment = 1'b0;
            RM_POS_INF: calc_increment = any & ~b.sign;
            RM_NEG_INF: calc_increment = any & b.sign;
            default:    calc_increment = b.guard & (b.rnd | b.sticky | b.lsb);
        endcase
    endfunction

    function automatic logic calc_ovf_inf(input rmode_e m, input logic sign);
        case (m)
            RM_ZERO:    calc_ovf_inf = 1'b0;
            RM_POS_INF: calc_ovf_inf = ~sign;
            RM_NEG_INF: calc_ovf_inf = sign;
            default:    calc_ovf_inf = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fp_round_decide.sv
module fp_round_decide
    import fp_round_pkg::*;
(
    input  rmode_e mode,
    input  rbits_t bits,
    output logic   incr,
    output logic   inexact,
    output logic   ovf_inf
);
    always_comb begin
        inexact = bits.guard | bits.rnd | bits.sticky;
        incr    = calc_increment(mode, bits);
        ovf_inf = calc_ovf_inf(mode, bits.sign);
    end
endmodule

// File: rtl/fp_round_incr.sv
module fp_round_incr #(
    parameter int W = 62
) (
    input  logic [W-1:0] trunc,
    input  logic         incr,
    output logic [W-1:0] sum
);
    always_comb sum = trunc + {{(W-1){1'b0}}, incr};
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
    import fp_round_pkg::*;
#(
    parameter int MANT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [MANT_W-1:0] mant_in,
    input  logic              sticky_in,
    input  logic              sign_in,
    input  logic [1:0]        mode_in,
    output logic              out_valid,
    output logic [MANT_W-3:0] mant_out,
    output logic              rnd_up,
    output logic              inexact,
    output logic              ovf_to_inf
);
    localparam int OUT_W = MANT_W - 2;

    logic [OUT_W-1:0] trunc_w;
    logic [OUT_W-1:0] sum_w;
    rbits_t           bits_w;
    rmode_e           mode_w;
    logic             incr_w;
    logic             inex_w;
    logic             ovf_w;

    assign trunc_w = mant_in[MANT_W-1:2];
    assign mode_w  = rmode_e'(mode_in);
    assign bits_w  = '{guard: mant_in[1], rnd: mant_in[0], sticky: sticky_in,
                       lsb: mant_in[2], sign: sign_in};

    fp_round_decide u_decide (
        .mode    (mode_w),
        .bits    (bits_w),
        .incr    (incr_w),
        .inexact (inex_w),
        .ovf_inf (ovf_w)
    );

    fp_round_incr #(.W(OUT_W)) u_incr (
        .trunc (trunc_w),
        .incr  (incr_w),
        .sum   (sum_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            mant_out   <= '0;
            rnd_up     <= 1'b0;
            inexact    <= 1'b0;
            ovf_to_inf <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            mant_out   <= sum_w;
            rnd_up     <= incr_w;
            inexact    <= inex_w;
            ovf_to_inf <= ovf_w;
        end
    end

    // Assertions next to the registered results
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));
    a_r4_exact_no_round: assert property (@(posedge clk) disable iff (rst)
        (mant_in[1:0] == 2'b00 && !sticky_in) |=> (!inexact && !rnd_up));
    a_r5_inexact_set: assert property (@(posedge clk) disable iff (rst)
        (mant_in[1:0] != 2'b00 || sticky_in) |=> inexact);
    a_r7_zero_mode: assert property (@(posedge clk) disable iff (rst)
        (mode_in == 2'd1) |=> !rnd_up);
    a_r3_mant_value: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> mant_out == $past(mant_in[MANT_W-1:2]) + {{(OUT_W-1){1'b0}}, rnd_up});
    a_r9_ovf_zero_mode: assert property (@(posedge clk) disable iff (rst)
        (mode_in == 2'd1) |=> !ovf_to_inf);
    a_r8_directed: assert property (@(posedge clk) disable iff (rst)
        rnd_up |-> (inexact || $past(mode_in) == 2'd0));
endmodule

// File: tb/tb_fp_round_unit.sv
module tb_fp_round_unit;
    localparam int MW = 64;
    localparam int OW = MW - 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [MW-1:0] mant_in = '0;
    logic          sticky_in = 1'b0;
    logic          sign_in = 1'b0;
    logic [1:0]    mode_in = 2'd0;
    logic          out_valid;
    logic [OW-1:0] mant_out;
    logic          rnd_up, inexact, ovf_to_inf;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fp_round_unit #(.MANT_W(MW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mant_in(mant_in),
        .sticky_in(sticky_in), .sign_in(sign_in), .mode_in(mode_in),
        .out_valid(out_valid), .mant_out(mant_out), .rnd_up(rnd_up),
        .inexact(inexact), .ovf_to_inf(ovf_to_inf)
    );

    function automatic logic ref_up(input logic [MW-1:0] m, input logic s,
                                    input logic sg, input logic [1:0] md);
        logic any;
        any = m[1] | m[0] | s;
        if (md == 2'd1)      return 1'b0;
        else if (md == 2'd2) return any & ~sg;
        else if (md == 2'd3) return any & sg;
        else                 return m[1] & (m[0] | s | m[2]);
    endfunction

    function automatic logic ref_inf(input logic sg, input logic [1:0] md);
        if (md == 2'd0) return 1'b1;
        if (md == 2'd1) return 1'b0;
        if (md == 2'd2) return ~sg;
        return sg;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one sample, check its result one cycle later
    task automatic run(input string req, input logic [MW-1:0] m, input logic s,
                       input logic sg, input logic [1:0] md);
        logic eu;
        logic [OW-1:0] em;
        eu = ref_up(m, s, sg, md);
        em = m[MW-1:2] + OW'(eu);
        mant_in = m; sticky_in = s; sign_in = sg; mode_in = md; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R2 valid"}, 64'(out_valid), 64'd1);
        chk({req, " R3 mant"}, 64'(mant_out), 64'(em));
        chk({req, " R6/R7/R8 up"}, 64'(rnd_up), 64'(eu));
        chk({req, " R5 inexact"}, 64'(inexact), 64'(m[1] | m[0] | s));
        chk({req, " R9 ovf"}, 64'(ovf_to_inf), 64'(ref_inf(sg, md)));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset mant", 64'(mant_out), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 post-reset valid", 64'(out_valid), 64'd0);

        // R4 exact in all modes
        for (int md = 0; md < 4; md++) run("R4", 64'h0000_0000_0000_0A14, 1'b0, md[0], 2'(md));
        // R6 ties-to-even
        run("R6 tie even", 64'b1010, 1'b0, 1'b0, 2'd0);
        run("R6 tie odd", 64'b1110, 1'b0, 1'b0, 2'd0);
        run("R6 above half", 64'b1011, 1'b0, 1'b0, 2'd0);
        run("R6 sticky", 64'b1010, 1'b1, 1'b1, 2'd0);
        run("R6 below half", 64'b1001, 1'b1, 1'b0, 2'd0);
        // R7 toward zero
        run("R7", 64'hFFFF, 1'b1, 1'b0, 2'd1);
        // R8 directed
        run("R8 pos+", 64'h100, 1'b1, 1'b0, 2'd2);
        run("R8 pos-", 64'h100, 1'b1, 1'b1, 2'd2);
        run("R8 neg-", 64'h101, 1'b0, 1'b1, 2'd3);
        run("R8 neg+", 64'h101, 1'b0, 1'b0, 2'd3);
        // R10 carry out wraps
        run("R10 wrap", {MW{1'b1}}, 1'b0, 1'b0, 2'd0);
        chk("R10 zero mant", 64'(mant_out), 64'd0);
        chk("R10 up", 64'(rnd_up), 64'd1);

        // random single samples
        for (int i = 0; i < 400; i++)
            run("rand", {$urandom, $urandom}, 1'($urandom), 1'($urandom), 2'($urandom));

        // R2 back-to-back stream
        begin
            logic [OW-1:0] pm;
            logic pv;
            pv = 1'b0; pm = '0;
            for (int i = 0; i < 200; i++) begin
                logic [MW-1:0] m;
                logic s, sg, v;
                logic [1:0] md;
                m = {$urandom, $urandom}; s = 1'($urandom); sg = 1'($urandom);
                md = 2'($urandom); v = 1'($urandom);
                mant_in = m; sticky_in = s; sign_in = sg; mode_in = md; in_valid = v;
                @(posedge clk); @(negedge clk);
                chk("R2 stream valid", 64'(out_valid), 64'(v));
                chk("R2 stream mant", 64'(mant_out), 64'(m[MW-1:2] + OW'(ref_up(m, s, sg, md))));
                pv = v; pm = mant_out;
            end
            in_valid = 1'b0;
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                compared++; mismatched++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule